// File: doc/BRIEF.md
# Daisy-Chain SPI Diagnostic Slave

This block is the serial front end of a multi-channel output driver. A host selects it with an active-low chip select and clocks command bits in on one wire while diagnosis bits come back on another. When the frame opens, the block takes a snapshot of a parallel diagnosis word into its shift register. It then moves out one bit per serial clock cycle, most significant bit first, and samples one incoming bit per cycle. When the frame closes, it hands the received word to the command logic with a single-cycle strobe, but only if the number of clocked bits was a whole, nonzero number of bytes.

A sticky transmission error flag is shown on serial out from chip-select fall until the first rising serial clock. During that window the pin carries the OR of the flag and the level on serial in. When several devices are chained, a high level at the host therefore means that some device in the chain saw a reset or a malformed frame. Once the frame is past its head, the bit that leaves the top of the shift register drives serial out. A frame longer than the register thus passes on to the next device after a delay of one word.

All three serial inputs are resynchronised to the system clock with two flops each. Edges are found in that clock domain, so the system clock must run at least four times faster than the serial clock.

Top module: `spi_diag_slave`

## Requirements
- R1: After reset, serial out is not driven, no commit strobe is given, the command word reads zero and the error flag is set.
- R2: Serial out is enabled exactly while the synchronised chip select is low. It is released when the frame ends.
- R3: From chip-select fall until the first rising serial clock, serial out shows the error flag ORed with the current serial in level.
- R4: At chip-select fall, the diagnosis word is loaded. After each rising serial clock, serial out shows the next bit of that word, most significant bit first.
- R5: Serial in is sampled on each falling serial clock and shifted in at the least significant end. The committed word is the last WORD_W bits that were shifted in, with any unfilled upper part holding the low diagnosis bits.
- R6: At chip-select rise after a nonzero multiple of 8 clocked bits, the block pulses cmd_valid high for exactly one system clock cycle while chip select is high. cmd_word changes only with that pulse.
- R7: An accepted frame clears the error flag, so the head of the next frame shows serial in alone.
- R8: A frame that ends with a bit count that is not a multiple of 8 gives no strobe and sets the error flag.
- R9: Serial clock and serial in activity while chip select is high has no effect: no strobe, serial out stays released, and the error flag is unchanged.
- R10: In a frame longer than WORD_W bits, the bits that appear on serial out after the first WORD_W are the bits received at the start of the frame, in order.
- R11: A frame with no serial clock edges at all gives no strobe and leaves the error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in |
| diag_word | input | WORD_W | Parallel diagnosis word, captured at frame start |
| sdo | output | 1 | Serial data out (valid while sdo_oe is high) |
| sdo_oe | output | 1 | Output enable for the serial out pad (low = high impedance) |
| cmd_word | output | WORD_W | Last accepted command word |
| cmd_valid | output | 1 | One-cycle strobe when cmd_word is updated |

## Verification
The bench goes after frames whose length is not a multiple of 8, and after frames with no clock at all. A design that counted badly would either commit a torn word or fail to raise the flag that the next frame's head must show. It also checks the head window with serial in held low and then high. A design that showed only the flag, or only serial in, would break error signalling in a daisy chain. Frames longer than one word check that the first received bits come back out in order, and a design that rotated the register instead of shifting it would fail that check. A reset in the middle of the run checks that the flag comes back set.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;

    // Position of the slave within a frame
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_HEAD  = 2'd1,
        PH_SHIFT = 2'd2
    } frame_ph_e;

    // Edge events seen in the system clock domain
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
    } spi_evt_t;

endpackage

// File: rtl/spi_diag_sync.sv
module spi_diag_sync #(
    parameter int unsigned   N       = 1,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/spi_diag_edge.sv
module spi_diag_edge
    import spi_diag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_s,
    input  logic     sck_s,
    output spi_evt_t evt_o
);

    typedef struct packed {
        logic cs_p;
        logic sck_p;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.cs_p  = cs_s;
        st_d.sck_p = sck_s;

        evt_o.cs_fall  =  st_q.cs_p & ~cs_s;
        evt_o.cs_rise  = ~st_q.cs_p &  cs_s;
        // serial clock edges only count inside a frame
        evt_o.sck_rise = ~cs_s & ~st_q.sck_p &  sck_s;
        evt_o.sck_fall = ~cs_s &  st_q.sck_p & ~sck_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_p  <= 1'b1;
            st_q.sck_p <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spi_diag_shifter.sv
module spi_diag_shifter
    import spi_diag_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi_evt_t          evt_i,
    input  logic              sdi_s,
    input  logic [WORD_W-1:0] load_i,
    output logic [WORD_W-1:0] word_o,
    output logic              out_bit_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              any_o
);

    localparam int unsigned MSB = WORD_W - 1;

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic              out_bit;
        logic [CNT_W-1:0]  cnt;
        logic              any;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt_i.cs_fall) begin
            st_d.sr      = load_i;
            st_d.out_bit = load_i[MSB];
            st_d.cnt     = '0;
            st_d.any     = 1'b0;
        end else begin
            // launch on rising serial clock
            if (evt_i.sck_rise) begin
                st_d.out_bit = st_q.sr[MSB];
            end
            // capture on falling serial clock, count modulo 2**CNT_W
            if (evt_i.sck_fall) begin
                st_d.sr  = {st_q.sr[MSB-1:0], sdi_s};
                st_d.cnt = st_q.cnt + CNT_W'(1);
                st_d.any = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o    = st_q.sr;
    assign out_bit_o = st_q.out_bit;
    assign cnt_o     = st_q.cnt;
    assign any_o     = st_q.any;

endmodule

// File: rtl/spi_diag_slave.sv
module spi_diag_slave
    import spi_diag_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [WORD_W-1:0] diag_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [WORD_W-1:0] cmd_word,
    output logic              cmd_valid
);

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned CNT_W     = $clog2(BYTE_BITS);

    typedef struct packed {
        frame_ph_e         phase;
        logic              terr;
        logic [WORD_W-1:0] cmd_word;
        logic              cmd_valid;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [2:0]        pins_s;
    logic              cs_s, sck_s, sdi_s;
    spi_evt_t          evt;
    logic [WORD_W-1:0] sr_word;
    logic              out_bit;
    logic [CNT_W-1:0]  bit_cnt;
    logic              any_bits;
    logic              cs_rise_w, frame_ok, frame_bad, frame_empty;

    // chip select idles high, so its synchroniser resets high
    spi_diag_sync #(.N(3), .RST_VAL(3'b100)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n, sclk, sdi}),
        .q_o   (pins_s)
    );

    assign cs_s  = pins_s[2];
    assign sck_s = pins_s[1];
    assign sdi_s = pins_s[0];

    spi_diag_edge edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_s  (cs_s),
        .sck_s (sck_s),
        .evt_o (evt)
    );

    spi_diag_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .sdi_s     (sdi_s),
        .load_i    (diag_word),
        .word_o    (sr_word),
        .out_bit_o (out_bit),
        .cnt_o     (bit_cnt),
        .any_o     (any_bits)
    );

    assign cs_rise_w   = evt.cs_rise;
    assign frame_ok    = any_bits & (bit_cnt == '0);
    assign frame_bad   = any_bits & (bit_cnt != '0);
    assign frame_empty = ~any_bits;

    always_comb begin
        st_d           = st_q;
        st_d.cmd_valid = 1'b0;
        if (evt.cs_fall) begin
            st_d.phase = PH_HEAD;
        end else if (evt.cs_rise) begin
            st_d.phase = PH_IDLE;
            if (frame_ok) begin
                st_d.cmd_word  = sr_word;
                st_d.cmd_valid = 1'b1;
                st_d.terr      = 1'b0;
            end else if (frame_bad) begin
                st_d.terr = 1'b1;
            end
        end else if (evt.sck_rise && st_q.phase == PH_HEAD) begin
            st_d.phase = PH_SHIFT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase     <= PH_IDLE;
            st_q.terr      <= 1'b1;
            st_q.cmd_word  <= '0;
            st_q.cmd_valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // head window: flag ORed with serial in, then shifted data
    assign sdo_oe    = ~cs_s;
    assign sdo       = cs_s ? 1'b0
                     : (st_q.phase == PH_SHIFT) ? out_bit
                     : (st_q.terr | sdi_s);
    assign cmd_word  = st_q.cmd_word;
    assign cmd_valid = st_q.cmd_valid;

endmodule

// File: rtl/spi_diag_slave_chk.sv
module spi_diag_slave_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [WORD_W-1:0] cmd_word,
    input logic              sdo_oe,
    input logic              cs_rise,
    input logic              frame_ok,
    input logic              frame_bad,
    input logic              frame_empty,
    input logic              terr_q
);

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R6
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !sdo_oe);

    // R6
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_word) |-> cmd_valid);

    // R7
    ok_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && frame_ok) |=> (!terr_q && cmd_valid));

    // R8
    bad_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && frame_bad) |=> (terr_q && !cmd_valid));

    // R11
    empty_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && frame_empty) |=> ($stable(terr_q) && !cmd_valid));

endmodule

bind spi_diag_slave spi_diag_slave_chk #(.WORD_W(WORD_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_word    (cmd_word),
    .sdo_oe      (sdo_oe),
    .cs_rise     (cs_rise_w),
    .frame_ok    (frame_ok),
    .frame_bad   (frame_bad),
    .frame_empty (frame_empty),
    .terr_q      (st_q.terr)
);

// File: tb/spi_diag_slave_tb.sv
module spi_diag_slave_tb_top;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned SETTLE     = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              sclk = 1'b0;
    logic              sdi = 1'b0;
    logic [WORD_W-1:0] diag_word = '0;
    logic              sdo, sdo_oe, cmd_valid;
    logic [WORD_W-1:0] cmd_word;

    int                vectors = 0;
    int                misses  = 0;
    int                strobes = 0;
    logic [WORD_W-1:0] last_word = '0;
    logic              model_terr = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_diag_slave #(.WORD_W(WORD_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .diag_word (diag_word),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .cmd_word  (cmd_word),
        .cmd_valid (cmd_valid)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            strobes   <= strobes + 1;
            last_word <= cmd_word;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic frame_accepted(input int nbits);
        return (nbits > 0) && (nbits % 8 == 0);
    endfunction

    // one complete frame, with every output bit and the commit checked
    task automatic run_frame(input logic [WORD_W-1:0] diag, input logic [63:0] tx,
                             input int nbits);
        logic [WORD_W-1:0] m;
        int                s0;
        logic              ok;
        diag_word = diag;
        step(3);
        s0 = strobes;
        cs_n = 1'b0;
        sdi  = 1'b0;
        step(SETTLE);
        check(sdo_oe == 1'b1, "R2", "enable in frame", 64'(sdo_oe), 64'd1);
        check(sdo == model_terr, "R3", "head with sdi low", 64'(sdo), 64'(model_terr));
        sdi = 1'b1;
        step(SETTLE);
        check(sdo == 1'b1, "R3", "head with sdi high", 64'(sdo), 64'd1);
        m = diag;
        for (int i = 0; i < nbits; i++) begin
            sdi  = tx[i];
            sclk = 1'b1;
            step(SETTLE);
            check(sdo == m[WORD_W-1], (i < WORD_W) ? "R4" : "R10", "shifted bit",
                  64'(sdo), 64'(m[WORD_W-1]));
            sclk = 1'b0;
            step(SETTLE);
            m = {m[WORD_W-2:0], tx[i]};
        end
        cs_n = 1'b1;
        step(SETTLE);
        check(sdo_oe == 1'b0, "R2", "release after frame", 64'(sdo_oe), 64'd0);
        ok = frame_accepted(nbits);
        check((strobes - s0) == (ok ? 1 : 0), ok ? "R6" : ((nbits == 0) ? "R11" : "R8"),
              "strobe count", 64'(strobes - s0), ok ? 64'd1 : 64'd0);
        if (ok) begin
            check(last_word == m, "R5", "committed word", 64'(last_word), 64'(m));
            check(cmd_word == m, "R6", "held word", 64'(cmd_word), 64'(m));
        end
        if (ok)             model_terr = 1'b0;
        else if (nbits > 0) model_terr = 1'b1;
        sdi = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int s0;
        void'($urandom(32'h5EED_0A17));
        step(4);
        rst_n = 1'b1;
        step(SETTLE);
        // R1 reset state
        check(sdo_oe == 1'b0, "R1", "enable after reset", 64'(sdo_oe), 64'd0);
        check(cmd_valid == 1'b0, "R1", "strobe after reset", 64'(cmd_valid), 64'd0);
        check(cmd_word == '0, "R1", "word after reset", 64'(cmd_word), 64'd0);

        // first frame after reset shows the flag (R1 via R3), then clears it (R7)
        run_frame(16'hA5C3, 64'h0000_0000_0000_3C96, 16);
        run_frame(16'h0F0F, 64'h0000_0000_0000_1234, 16);   // head now shows sdi only, R7
        // short byte commit, upper part holds low diag bits, R5
        run_frame(16'hBEEF, 64'h0000_0000_0000_005A, 8);
        // torn frame, R8
        run_frame(16'h1111, 64'h0000_0000_0000_1FFF, 13);
        run_frame(16'h2222, 64'h0000_0000_0000_FFFF, 0);     // empty frame keeps flag set, R11
        run_frame(16'h3333, 64'h0000_0000_0000_8001, 16);
        run_frame(16'h4444, 64'h0000_0000_0000_0000, 0);     // empty frame keeps flag clear, R11

        // R9 activity while deselected
        s0 = strobes;
        for (int k = 0; k < 8; k++) begin
            sdi  = k[0];
            sclk = 1'b1;
            step(SETTLE);
            check(sdo_oe == 1'b0, "R9", "enable while deselected", 64'(sdo_oe), 64'd0);
            sclk = 1'b0;
            step(SETTLE);
        end
        check(strobes == s0, "R9", "no strobe while deselected", 64'(strobes - s0), 64'd0);
        run_frame(16'h5555, 64'h0000_0000_0000_00C3, 8);     // flag unchanged at head, R9

        // daisy chain pass-through, R10
        run_frame(16'hC0DE, 64'h0000_00AB_CDEF_1357, 40);
        run_frame(16'h7E81, 64'h0000_0000_0096_6996, 24);

        // R1 reset between frames sets the flag again
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        model_terr = 1'b1;
        step(SETTLE);
        check(cmd_word == '0, "R1", "word after second reset", 64'(cmd_word), 64'd0);
        run_frame(16'h9999, 64'h0000_0000_0000_0F0F, 16);

        // constrained random frames
        for (int f = 0; f < 24; f++) begin
            int   r;
            int   nb;
            logic [63:0] tx;
            r  = int'($urandom % 4);
            nb = (r < 3) ? int'(8 * (1 + $urandom % 5)) : int'(1 + $urandom % 40);
            tx = {$urandom, $urandom};
            run_frame(WORD_W'($urandom), tx, nb);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule